// File: doc/BRIEF.md
# Multi-slot TDM audio serializer

This block is the transmit half of a serial audio port that runs as clock master. It divides a bit clock from the system clock and drives a frame sync and one serial data line. Up to four channel pairs share that line as time slots of one TDM frame. Each pair has its own enable, mono or stereo mode and starting slot. The number of slots per frame and the slot length are programmable. The sample width is common to every channel.

Samples enter a shared eight-entry FIFO through a valid/ready push port. They leave it one per occupied slot, in slot order. A level-based request tells a DMA engine when the FIFO runs low. When an occupied slot begins and no sample is waiting, the slot carries zeros and a sticky flag records the underrun.

Top module: `tdm_audio_tx`

## Requirements
- R1: The internal bit clock has a period of 2*(cfg_sck_div+1) system clock cycles. With cfg_sck_invert=0, sd_o changes only while sck_o is low and is sampled on the rising edge of sck_o. cfg_sck_invert=1 inverts sck_o.
- R2: A frame has cfg_slot_cnt_m1+1 slots of cfg_slot_len_m1+1 bits each, with cfg_slot_len_m1 >= cfg_word_len_m1. Each occupied slot carries W = cfg_word_len_m1+1 bits of s_data[W-1:0], MSB first. Bits of s_data above W are ignored.
- R3: With cfg_right_just=0 the W data bits fill the first W bit times of the slot. With cfg_right_just=1 they fill the last W bit times. All other bit times of the slot are 0.
- R4: Pair p (bits p of cfg_pair_on and cfg_pair_mono, field cfg_pair_slot[3p+2:3p]) occupies slot b when it is enabled. A stereo pair also occupies slot b+1 when that slot exists in the frame. A slot that no pair occupies sends zeros and consumes no sample.
- R5: Each occupied slot takes exactly one FIFO entry, in FIFO order, as frame slots 0, 1, 2 ... are reached.
- R6: The FIFO holds 8 samples. s_ready is low while it is full, and a word offered while s_ready is low is not stored.
- R7: dma_req is high exactly when the FIFO fill level is at or below cfg_req_thresh.
- R8: When an occupied slot starts with the FIFO empty, that slot sends zeros and underrun goes high. underrun stays high until cfg_enable is low.
- R9: The frame sync ws_o is active at the first bit of each frame. In normal mode (cfg_short_sync=0) it stays active for the first floor(N/2) bit times of the N-bit frame. In short mode it is active for the first bit time only. The active level is high, or low when cfg_ws_invert=1.
- R10: While cfg_enable is low, sck_o rests at 1 xor cfg_sck_invert, ws_o is inactive, sd_o is 0 and underrun is 0. The FIFO still accepts pushes, so it can be preloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Run the serializer; low stops it and clears its state |
| cfg_word_len_m1 | input | 5 | Sample width minus one (3..31) |
| cfg_slot_len_m1 | input | 6 | Slot length in bit times minus one |
| cfg_slot_cnt_m1 | input | 3 | Slots per frame minus one |
| cfg_right_just | input | 1 | 1: data at the end of the slot, 0: at the start |
| cfg_short_sync | input | 1 | 1: one-bit frame sync, 0: half-frame sync |
| cfg_sck_invert | input | 1 | Invert bit clock output |
| cfg_ws_invert | input | 1 | Invert frame sync output |
| cfg_sck_div | input | 8 | Half bit-clock period in system cycles minus one |
| cfg_pair_on | input | 4 | Per-pair enable |
| cfg_pair_mono | input | 4 | Per-pair mono select |
| cfg_pair_slot | input | 12 | Per-pair first slot, 3 bits per pair |
| cfg_req_thresh | input | 4 | FIFO level at or below which dma_req is raised |
| s_valid | input | 1 | Sample push valid |
| s_data | input | 32 | Sample, right-aligned |
| s_ready | output | 1 | FIFO can take a sample |
| dma_req | output | 1 | FIFO low-level request |
| underrun | output | 1 | Sticky underrun flag |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |

## Verification
Two situations are hard to reach from the ports. One is a FIFO that is full while a further word is offered. The other is a FIFO that runs dry partway through a frame while earlier slots still carry real samples. The bench reaches both by preloading the FIFO while the serializer is stopped, holding an extra word on the push port with s_ready low, and then running more occupied slots than there are samples. Slot patterns include unoccupied slots, overlapping pairs and a stereo pair whose second slot falls outside the frame. These are swept against every width, justification, sync mode and polarity, and each received slot is compared with a value built arithmetically.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int SAMPLE_W    = 32;
    localparam int WLEN_W      = $clog2(SAMPLE_W);
    localparam int SLEN_W      = WLEN_W + 1;
    localparam int SLOT_IDX_W  = 3;
    localparam int FRAME_BIT_W = SLOT_IDX_W + SLEN_W + 1;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        logic [WLEN_W-1:0]     word_m1;
        logic [SLEN_W-1:0]     slot_len_m1;
        logic [SLOT_IDX_W-1:0] slots_m1;
        logic                  right_just;
        logic                  short_sync;
    } frame_cfg_t;

    typedef struct packed {
        logic [SLOT_IDX_W-1:0]  slot;
        logic [SLEN_W-1:0]      bitpos;
        logic [FRAME_BIT_W-1:0] fbit;
    } frame_pos_t;

    // Total bit times in one frame
    function automatic logic [FRAME_BIT_W-1:0] frame_len(input frame_cfg_t c);
        logic [FRAME_BIT_W-1:0] a;
        logic [FRAME_BIT_W-1:0] b;
        a = FRAME_BIT_W'(c.slots_m1) + FRAME_BIT_W'(1);
        b = FRAME_BIT_W'(c.slot_len_m1) + FRAME_BIT_W'(1);
        return a * b;
    endfunction

    // Serial bit for position b of a slot holding sample s
    function automatic logic slot_bit(input sample_t s, input frame_cfg_t c,
                                      input logic [SLEN_W-1:0] b);
        logic [SLEN_W:0] off;
        logic [SLEN_W:0] rel;
        off = c.right_just ? ({1'b0, c.slot_len_m1} - {2'b00, c.word_m1}) : '0;
        rel = {1'b0, b} - off;
        if (({1'b0, b} < off) || (rel > {2'b00, c.word_m1}))
            return 1'b0;
        return s[c.word_m1 - rel[WLEN_W-1:0]];
    endfunction

    // Un-inverted frame sync level for frame bit position fb
    function automatic logic sync_level(input frame_cfg_t c,
                                        input logic [FRAME_BIT_W-1:0] fb);
        logic [FRAME_BIT_W-1:0] half;
        half = frame_len(c) >> 1;
        return c.short_sync ? (fb == '0) : (fb < half);
    endfunction

endpackage

// File: rtl/tdm_fifo.sv
module tdm_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full  = (level == LVL_W'(DEPTH));
    assign empty = (level == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push)
                wr_ptr <= bump(wr_ptr);
            if (pop)
                rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/tdm_sck_gen.sv
module tdm_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             sck_lvl,
    output logic             fall_step
);

    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick      = run && (cnt == half_m1);
    assign fall_step = tick && sck_lvl;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt     <= '0;
            sck_lvl <= 1'b1;
        end else if (tick) begin
            cnt     <= '0;
            sck_lvl <= !sck_lvl;
        end else begin
            cnt     <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq
    import tdm_tx_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            run,
    input  logic                            step,
    input  frame_cfg_t                      cfg,
    input  logic [NUM_PAIRS-1:0]            pair_on,
    input  logic [NUM_PAIRS-1:0]            pair_mono,
    input  logic [NUM_PAIRS*SLOT_IDX_W-1:0] pair_slot,
    input  logic                            fifo_empty,
    input  sample_t                         fifo_head,
    output logic                            fifo_pop,
    output logic                            sd_int,
    output logic                            ws_int,
    output logic                            starved
);

    frame_pos_t           pos;
    sample_t              held;
    sample_t              now_sample;
    logic [NUM_PAIRS-1:0] hit;
    logic                 owned;
    logic                 slot_head;
    logic                 last_bit;
    logic                 last_slot;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic [SLOT_IDX_W-1:0] base;
        assign base   = pair_slot[p*SLOT_IDX_W +: SLOT_IDX_W];
        assign hit[p] = pair_on[p] &&
                        ((pos.slot == base) ||
                         (!pair_mono[p] && ({1'b0, pos.slot} == ({1'b0, base} + 1'b1))));
    end

    assign owned     = |hit;
    assign slot_head = (pos.bitpos == '0);
    assign last_bit  = (pos.bitpos == cfg.slot_len_m1);
    assign last_slot = (pos.slot == cfg.slots_m1);
    assign fifo_pop  = step && slot_head && owned && !fifo_empty;

    always_comb begin
        if (!slot_head)
            now_sample = held;
        else if (owned && !fifo_empty)
            now_sample = fifo_head;
        else
            now_sample = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos     <= '0;
            held    <= '0;
            sd_int  <= 1'b0;
            ws_int  <= 1'b0;
            starved <= 1'b0;
        end else if (step) begin
            sd_int <= slot_bit(now_sample, cfg, pos.bitpos);
            ws_int <= sync_level(cfg, pos.fbit);
            held   <= now_sample;
            if (slot_head && owned && fifo_empty)
                starved <= 1'b1;
            if (!last_bit) begin
                pos.bitpos <= pos.bitpos + SLEN_W'(1);
                pos.fbit   <= pos.fbit + FRAME_BIT_W'(1);
            end else begin
                pos.bitpos <= '0;
                if (last_slot) begin
                    pos.slot <= '0;
                    pos.fbit <= '0;
                end else begin
                    pos.slot <= pos.slot + SLOT_IDX_W'(1);
                    pos.fbit <= pos.fbit + FRAME_BIT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/tdm_audio_tx.sv
module tdm_audio_tx
    import tdm_tx_pkg::*;
#(
    parameter int NUM_PAIRS  = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 8,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cfg_enable,
    input  logic [WLEN_W-1:0]               cfg_word_len_m1,
    input  logic [SLEN_W-1:0]               cfg_slot_len_m1,
    input  logic [SLOT_IDX_W-1:0]           cfg_slot_cnt_m1,
    input  logic                            cfg_right_just,
    input  logic                            cfg_short_sync,
    input  logic                            cfg_sck_invert,
    input  logic                            cfg_ws_invert,
    input  logic [DIV_W-1:0]                cfg_sck_div,
    input  logic [NUM_PAIRS-1:0]            cfg_pair_on,
    input  logic [NUM_PAIRS-1:0]            cfg_pair_mono,
    input  logic [NUM_PAIRS*SLOT_IDX_W-1:0] cfg_pair_slot,
    input  logic [LVL_W-1:0]                cfg_req_thresh,
    input  logic                            s_valid,
    input  logic [SAMPLE_W-1:0]             s_data,
    output logic                            s_ready,
    output logic                            dma_req,
    output logic                            underrun,
    output logic                            sck_o,
    output logic                            ws_o,
    output logic                            sd_o
);

    frame_cfg_t       fcfg;
    sample_t          fifo_head;
    logic [LVL_W-1:0] fifo_level;
    logic             fifo_full;
    logic             fifo_empty;
    logic             fifo_pop;
    logic             fifo_push;
    logic             sck_lvl;
    logic             fall_step;
    logic             sd_int;
    logic             ws_int;

    assign fcfg.word_m1     = cfg_word_len_m1;
    assign fcfg.slot_len_m1 = cfg_slot_len_m1;
    assign fcfg.slots_m1    = cfg_slot_cnt_m1;
    assign fcfg.right_just  = cfg_right_just;
    assign fcfg.short_sync  = cfg_short_sync;

    assign s_ready   = !fifo_full;
    assign fifo_push = s_valid && !fifo_full;
    assign dma_req   = (fifo_level <= cfg_req_thresh);

    tdm_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (SAMPLE_W)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (fifo_push),
        .push_data (s_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .level     (fifo_level),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    tdm_sck_gen #(
        .DIV_W (DIV_W)
    ) u_sck (
        .clk       (clk),
        .rst       (rst),
        .run       (cfg_enable),
        .half_m1   (cfg_sck_div),
        .sck_lvl   (sck_lvl),
        .fall_step (fall_step)
    );

    tdm_frame_seq #(
        .NUM_PAIRS (NUM_PAIRS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .run        (cfg_enable),
        .step       (fall_step),
        .cfg        (fcfg),
        .pair_on    (cfg_pair_on),
        .pair_mono  (cfg_pair_mono),
        .pair_slot  (cfg_pair_slot),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .fifo_pop   (fifo_pop),
        .sd_int     (sd_int),
        .ws_int     (ws_int),
        .starved    (underrun)
    );

    assign sck_o = sck_lvl ^ cfg_sck_invert;
    assign ws_o  = ws_int ^ cfg_ws_invert;
    assign sd_o  = sd_int;

endmodule

// File: rtl/tdm_audio_tx_chk.sv
module tdm_audio_tx_chk #(
    parameter int FIFO_DEPTH = 8,
    parameter int LVL_W      = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_enable,
    input logic             cfg_sck_invert,
    input logic             cfg_ws_invert,
    input logic             s_valid,
    input logic             s_ready,
    input logic             dma_req,
    input logic             underrun,
    input logic             sck_o,
    input logic             ws_o,
    input logic             sd_o,
    input logic [LVL_W-1:0] fifo_level,
    input logic             fifo_pop
);

    // R10: a stopped serializer holds its outputs at rest
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> (sd_o == 1'b0 && underrun == 1'b0 &&
                         sck_o == !cfg_sck_invert && ws_o == cfg_ws_invert));

    // R6: the fill level never passes the depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LVL_W'(FIFO_DEPTH));

    // R6: an accepted push without a pop raises the level by one
    p_push_count_r6: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready && !fifo_pop) |=> (fifo_level == $past(fifo_level) + LVL_W'(1)));

    // R7: an empty FIFO always requests
    p_empty_req_r7: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == '0) |-> dma_req);

    // R8: underrun is sticky while running
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (underrun && cfg_enable) |=> underrun);

    // R1: data moves only on the inactive clock edge
    p_sd_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && $past(cfg_enable) && $stable(cfg_sck_invert) && !$stable(sd_o))
            |-> (sck_o == cfg_sck_invert));

endmodule

bind tdm_audio_tx tdm_audio_tx_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .LVL_W      (LVL_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_enable     (cfg_enable),
    .cfg_sck_invert (cfg_sck_invert),
    .cfg_ws_invert  (cfg_ws_invert),
    .s_valid        (s_valid),
    .s_ready        (s_ready),
    .dma_req        (dma_req),
    .underrun       (underrun),
    .sck_o          (sck_o),
    .ws_o           (ws_o),
    .sd_o           (sd_o),
    .fifo_level     (fifo_level),
    .fifo_pop       (fifo_pop)
);

// File: tb/test_tdm_audio_tx.sv
module test_tdm_audio_tx;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_enable;
    logic [4:0]  cfg_word_len_m1;
    logic [5:0]  cfg_slot_len_m1;
    logic [2:0]  cfg_slot_cnt_m1;
    logic        cfg_right_just;
    logic        cfg_short_sync;
    logic        cfg_sck_invert;
    logic        cfg_ws_invert;
    logic [7:0]  cfg_sck_div;
    logic [3:0]  cfg_pair_on;
    logic [3:0]  cfg_pair_mono;
    logic [11:0] cfg_pair_slot;
    logic [3:0]  cfg_req_thresh;
    logic        s_valid;
    logic [31:0] s_data;
    logic        s_ready;
    logic        dma_req;
    logic        underrun;
    logic        sck_o;
    logic        ws_o;
    logic        sd_o;

    always #4 clk = ~clk;

    tdm_audio_tx i_tdm_audio_tx (
        .clk             (clk),
        .rst             (rst),
        .cfg_enable      (cfg_enable),
        .cfg_word_len_m1 (cfg_word_len_m1),
        .cfg_slot_len_m1 (cfg_slot_len_m1),
        .cfg_slot_cnt_m1 (cfg_slot_cnt_m1),
        .cfg_right_just  (cfg_right_just),
        .cfg_short_sync  (cfg_short_sync),
        .cfg_sck_invert  (cfg_sck_invert),
        .cfg_ws_invert   (cfg_ws_invert),
        .cfg_sck_div     (cfg_sck_div),
        .cfg_pair_on     (cfg_pair_on),
        .cfg_pair_mono   (cfg_pair_mono),
        .cfg_pair_slot   (cfg_pair_slot),
        .cfg_req_thresh  (cfg_req_thresh),
        .s_valid         (s_valid),
        .s_data          (s_data),
        .s_ready         (s_ready),
        .dma_req         (dma_req),
        .underrun        (underrun),
        .sck_o           (sck_o),
        .ws_o            (ws_o),
        .sd_o            (sd_o)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;
    int          pushed;
    logic        prev_lvl;
    logic [31:0] samp [0:63];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic bit slot_owned(input int s);
        for (int p = 0; p < 4; p++) begin
            int b;
            b = int'(cfg_pair_slot[p*3 +: 3]);
            if (cfg_pair_on[p] && (s == b || (!cfg_pair_mono[p] && s == b + 1)))
                return 1;
        end
        return 0;
    endfunction

    task automatic fill_samples(input int seed);
        for (int i = 0; i < 64; i++)
            samp[i] = (32'(i + 1) * 32'h9E3779B1) ^ (32'(seed) * 32'h01000193);
    endtask

    task automatic set_pattern(input int pat);
        case (pat)
            0: begin // two stereo pairs over four slots
                cfg_slot_cnt_m1 = 3'd3; cfg_pair_on = 4'b0011; cfg_pair_mono = 4'b0000;
                cfg_pair_slot = {3'd0, 3'd0, 3'd2, 3'd0};
            end
            1: begin // mixed mono/stereo, slots 3 and 4 empty
                cfg_slot_cnt_m1 = 3'd5; cfg_pair_on = 4'b0111; cfg_pair_mono = 4'b0101;
                cfg_pair_slot = {3'd0, 3'd0, 3'd1, 3'd5};
            end
            default: begin // overlaps and a right slot past the frame end
                cfg_slot_cnt_m1 = 3'd7; cfg_pair_on = 4'b1111; cfg_pair_mono = 4'b1010;
                cfg_pair_slot = {3'd2, 3'd7, 3'd6, 3'd6};
            end
        endcase
    endtask

    task automatic idle_check(input string what);
        check(sck_o === !cfg_sck_invert, "R10", {what, " sck rest"}, 64'(sck_o), 64'(!cfg_sck_invert));
        check(ws_o === cfg_ws_invert, "R10", {what, " ws rest"}, 64'(ws_o), 64'(cfg_ws_invert));
        check(sd_o === 1'b0 && underrun === 1'b0, "R10", {what, " sd/underrun rest"},
              64'({sd_o, underrun}), 64'd0);
    endtask

    task automatic feeder(input int first, input int last);
        for (int i = first; i < last; i++) begin
            @(negedge clk);
            s_valid = 1'b0;
            while (!s_ready) @(negedge clk);
            s_valid = 1'b1;
            s_data  = samp[i];
            @(posedge clk);
            pushed++;
        end
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic next_edge(output logic d, output logic w, output int cyc);
        bit got;
        got = 0;
        cyc = 0;
        while (!got) begin
            logic cur;
            @(negedge clk);
            cyc++;
            cur = sck_o ^ cfg_sck_invert;
            if (!prev_lvl && cur) begin
                got = 1;
                d = sd_o;
                w = ws_o;
            end
            prev_lvl = cur;
        end
    endtask

    task automatic receive(input int nsamp, input int nframes, input int div);
        int W, L, S, k, off;
        bit exp_under;
        W = int'(cfg_word_len_m1) + 1;
        L = int'(cfg_slot_len_m1) + 1;
        S = int'(cfg_slot_cnt_m1) + 1;
        off = cfg_right_just ? (L - W) : 0;
        k = 0;
        exp_under = 0;
        while (pushed < ((nsamp < 8) ? nsamp : 8)) @(negedge clk);
        @(negedge clk);
        cfg_enable = 1'b1;
        prev_lvl = 1'b1;
        for (int f = 0; f < nframes; f++) begin
            for (int s = 0; s < S; s++) begin
                logic [31:0] cur;
                logic [63:0] got_sd, got_ws, exp_sd, exp_ws;
                bit own;
                string tag;
                own = slot_owned(s);
                cur = '0;
                tag = own ? (cfg_right_just ? "R3" : "R2") : "R4";
                if (own) begin
                    if (k < nsamp) begin
                        cur = samp[k];
                        k++;
                    end else begin
                        exp_under = 1;
                        tag = "R8";
                    end
                end
                got_sd = '0; got_ws = '0; exp_sd = '0; exp_ws = '0;
                for (int b = 0; b < L; b++) begin
                    logic d, w;
                    int cyc, fb;
                    next_edge(d, w, cyc);
                    got_sd[b] = d;
                    got_ws[b] = w;
                    if (f == 0 && s == 0 && b == 1)
                        check(cyc == 2 * (div + 1), "R1", "bit clock period", 64'(cyc), 64'(2 * (div + 1)));
                    if (b >= off && b < off + W)
                        exp_sd[b] = cur[W - 1 - (b - off)];
                    fb = s * L + b;
                    exp_ws[b] = (cfg_short_sync ? (fb == 0) : (fb < (S * L) / 2)) ^ cfg_ws_invert;
                end
                check(got_sd === exp_sd, tag, $sformatf("slot data f%0d s%0d (R5 order)", f, s), got_sd, exp_sd);
                check(got_ws === exp_ws, "R9", $sformatf("sync f%0d s%0d", f, s), got_ws, exp_ws);
            end
        end
        check(underrun === exp_under, "R8", "underrun flag", 64'(underrun), 64'(exp_under));
        cfg_enable = 1'b0;
    endtask

    task automatic run_case(input int preload, input int nsamp, input int nframes, input int div);
        cfg_sck_div = 8'(div);
        pushed = preload;
        repeat (2) @(negedge clk);
        fork
            feeder(preload, nsamp);
            receive(nsamp, nframes, div);
        join
        @(negedge clk);
        idle_check("after run");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        cfg_enable = 1'b0;
        cfg_word_len_m1 = 5'd15;
        cfg_slot_len_m1 = 6'd15;
        cfg_right_just = 1'b0;
        cfg_short_sync = 1'b0;
        cfg_sck_invert = 1'b0;
        cfg_ws_invert = 1'b0;
        cfg_sck_div = 8'd0;
        cfg_req_thresh = 4'd2;
        s_valid = 1'b0;
        s_data = '0;
        set_pattern(0);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        idle_check("reset");
        check(s_ready === 1'b1, "R6", "ready after reset", 64'(s_ready), 64'd1);
        check(dma_req === 1'b1, "R7", "request when empty", 64'(dma_req), 64'd1);

        // Sweep: widths x justification x sync mode, patterns and polarities mixed in
        for (int rj = 0; rj < 2; rj++) begin
            for (int ws = 0; ws < 4; ws++) begin
                for (int ss = 0; ss < 2; ss++) begin
                    int W, nown;
                    W = (ws == 0) ? 4 : (ws == 1) ? 7 : (ws == 2) ? 16 : 32;
                    cfg_word_len_m1 = 5'(W - 1);
                    cfg_slot_len_m1 = (W == 32) ? 6'd31 : 6'(W + 2);
                    cfg_right_just = 1'(rj);
                    cfg_short_sync = 1'(ss);
                    cfg_sck_invert = 1'(ws);
                    cfg_ws_invert = 1'(ss ^ rj);
                    set_pattern((ws + rj + ss) % 3);
                    nown = 0;
                    for (int s = 0; s <= int'(cfg_slot_cnt_m1); s++)
                        if (slot_owned(s)) nown++;
                    fill_samples(rj * 8 + ws * 2 + ss);
                    run_case(0, 2 * nown, 2, ws % 2);
                end
            end
        end

        // R6/R7: preload while stopped, watch request and ready, refuse a ninth word
        cfg_word_len_m1 = 5'd11;
        cfg_slot_len_m1 = 6'd13;
        cfg_right_just = 1'b1;
        cfg_short_sync = 1'b0;
        cfg_sck_invert = 1'b0;
        cfg_ws_invert = 1'b0;
        cfg_req_thresh = 4'd3;
        set_pattern(0);
        fill_samples(77);
        @(negedge clk);
        for (int i = 0; i <= 8; i++) begin
            check(dma_req === (i <= 3), "R7", $sformatf("request at level %0d", i),
                  64'(dma_req), 64'(i <= 3));
            check(s_ready === (i < 8), "R6", $sformatf("ready at level %0d", i),
                  64'(s_ready), 64'(i < 8));
            if (i < 8) begin
                s_valid = 1'b1;
                s_data = samp[i];
                @(negedge clk);
                s_valid = 1'b0;
            end
        end
        s_valid = 1'b1;
        s_data = 32'hDEAD_BEEF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(s_ready === 1'b0, "R6", "ready while full", 64'(s_ready), 64'd0);
        end
        s_valid = 1'b0;
        // 12 occupied slots over 3 frames with only 8 stored: last frame starves (R8)
        run_case(8, 8, 3, 2);
        check(dma_req === 1'b1, "R7", "request after drain", 64'(dma_req), 64'd1);

        finish_run();
    end

endmodule